// File: doc/BRIEF.md
# MFM Write Precompensation Unit

This block sits between an MFM encoder and the write driver of a disc channel. It takes one transition flag per half-bit cell and turns each set flag into a single write pulse. The pulse is placed inside its cell at a nominal point. In double-density operation with precompensation enabled, the pulse is instead moved one or two timing steps early or late. The direction and size of the move depend on the transitions two and three cells away on either side. This offsets the peak shift that the medium causes when transitions crowd together.

The block runs on a fast clock, and one clock period is one timing step. A half-bit cell lasts `SLOT_CYCLES` periods. A shift unit of 125 ns equals `STEP_CYCLES` periods. The block paces the incoming stream itself. In the last cycle of every cell it raises `cell_take`, and on the following edge it samples `flag_in`. A flag therefore emerges three cells after it was taken, once the neighbours on the later side are known. An upstream encoder changes `flag_in` after each `cell_take`.

Top module: `mfm_precomp`

## Requirements
- R1: While `rst_n` is low, `wr_pulse` and `cell_take` are low. After reset is released, `cell_take` first rises SLOT_CYCLES-1 cycles later.
- R2: `cell_take` is high for exactly one cycle in every SLOT_CYCLES cycles, and `flag_in` is sampled on the edge that ends that cycle.
- R3: A flag of 1 sampled at capture edge k produces exactly one `wr_pulse`, inside the cell that begins at capture edge k+3. A cell whose flag is 0 produces no pulse.
- R4: An unshifted pulse is high in cycle NOM+1 of its cell, counting the cycle after the capture edge as cycle 0, where NOM = SLOT_CYCLES/2. A shift of s steps moves the pulse to cycle NOM+1+s·STEP_CYCLES, with early being negative.
- R5: Let the later outer/inner neighbours (cells +3, +2) be L = {c+3, c+2}, and the earlier inner/outer neighbours (cells −2, −3) be E = {c−2, c−3}. Then L=00 with E=01 gives +1 step, and L=00 with E=10 gives +2 steps.
- R6: L=01 with E=00 gives −2 steps, and L=01 with E=01 gives −1 step.
- R7: L=10 with E=00 gives −1 step, and L=10 with E=10 gives +1 step.
- R8: Every other L/E combination, including any with L=11 or E=11, gives no shift.
- R9: If either adjacent cell (c−1 or c+1) holds a transition, which is illegal in MFM, the pulse is not shifted.
- R10: With `dd_mode` low (single density) or `pc_en` low, every pulse sits at the nominal position.
- R11: `wr_pulse` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock, one period per shift step unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| dd_mode | input | 1 | 1 = double density (MFM), 0 = single density |
| pc_en | input | 1 | 1 = apply precompensation shifts |
| flag_in | input | 1 | Transition flag of the next half-bit cell |
| cell_take | output | 1 | High in the cycle before `flag_in` is sampled |
| wr_pulse | output | 1 | One-cycle write pulse, timed within its cell |

## Verification
A pulse shifted the full two steps late becomes visible in the last cycle of its cell. That is the same cycle in which `cell_take` is high and the window is about to advance. The late and mixed stream scenarios provoke this. The bench judges it by attributing every pulse to the cell counted from captures, and by requiring that this pulse lands in the expected cycle without disturbing the pulse of the following cell.

// File: rtl/mfm_precomp.sv
module mfm_precomp #(
  parameter int SLOT_CYCLES = 8,
  parameter int STEP_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dd_mode,
  input  logic pc_en,
  input  logic flag_in,
  output logic cell_take,
  output logic wr_pulse
);

  localparam int CW   = $clog2(SLOT_CYCLES);
  localparam int NOM  = SLOT_CYCLES / 2;
  localparam int LAST = SLOT_CYCLES - 1;

  logic [CW-1:0] cnt;
  logic [6:0]    win;
  logic [1:0]    lat, ear;
  logic          adj, hit;
  int            sh, target;

  assign cell_take = (int'(cnt) == LAST);
  assign lat = {win[0], win[1]};
  assign ear = {win[5], win[6]};
  assign adj = win[2] | win[4];

  always_comb begin
    case ({lat, ear})
      4'b0001: sh = 1;
      4'b0010: sh = 2;
      4'b0100: sh = -2;
      4'b0101: sh = -1;
      4'b1000: sh = -1;
      4'b1010: sh = 1;
      default: sh = 0;
    endcase
    if (!dd_mode || !pc_en || adj) sh = 0;
    target = NOM + sh * STEP_CYCLES;
  end

  assign hit = win[3] && (int'(cnt) == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      win      <= '0;
      wr_pulse <= 1'b0;
    end else begin
      cnt      <= cell_take ? '0 : cnt + 1'b1;
      wr_pulse <= hit;
      if (cell_take) win <= {win[5:0], flag_in};
    end
  end

  // R11
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  // R2
  take_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cell_take) |-> (cnt == '0 && !cell_take));

  // R4
  pulse_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> (int'(cnt) >= NOM - 2*STEP_CYCLES + 1 && int'(cnt) <= NOM + 2*STEP_CYCLES + 1));

  // R10
  plain_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && $past(!dd_mode || !pc_en)) |-> int'(cnt) == NOM + 1);

endmodule

// File: tb/mfm_precomp_bench.sv
module mfm_precomp_bench;
  localparam int SLOT = 8;
  localparam int STEP = 1;
  localparam int NOM  = SLOT / 2;

  logic clk = 0, rst_n = 0, dd_mode = 1, pc_en = 1, flag_in = 0;
  logic cell_take, wr_pulse;
  int checks = 0, errors = 0;
  int ph, sc, stray, wide;
  int pcount [0:63];
  int pph [0:63];
  logic prev_pulse;

  mfm_precomp #(.SLOT_CYCLES(SLOT), .STEP_CYCLES(STEP)) u_mfm_precomp (
    .clk(clk), .rst_n(rst_n), .dd_mode(dd_mode), .pc_en(pc_en),
    .flag_in(flag_in), .cell_take(cell_take), .wr_pulse(wr_pulse));

  always #5 clk = ~clk;

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      ph = 0; sc = 0; prev_pulse = 0;
    end else begin
      if (wr_pulse && prev_pulse) wide++;
      prev_pulse = wr_pulse;
      if (wr_pulse) begin
        if (sc - 4 >= 0 && sc - 4 < 64) begin
          pcount[sc-4]++;
          pph[sc-4] = ph;
        end else stray++;
      end
      if (cell_take) begin ph = 0; sc++; end
      else ph++;
    end
  end

  function automatic int bitv(logic [63:0] s, int n, int j);
    return (j < 0 || j >= n) ? 0 : int'(s[j]);
  endfunction

  function automatic int exp_shift(logic [63:0] s, int n, int j, logic dd, logic en);
    int code;
    if (!dd || !en) return 0;                                  // R10
    if (bitv(s, n, j-1) != 0 || bitv(s, n, j+1) != 0) return 0; // R9
    code = bitv(s,n,j+3)*8 + bitv(s,n,j+2)*4 + bitv(s,n,j-2)*2 + bitv(s,n,j-3);
    case (code)
      1: return 1;  2: return 2;                 // R5
      4: return -2; 5: return -1;                // R6
      8: return -1; 10: return 1;                // R7
      default: return 0;                         // R8
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 0;
    for (int i = 0; i < 64; i++) begin pcount[i] = 0; pph[i] = 0; end
    stray = 0; wide = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic play(logic [63:0] s, int n, logic dd, logic en, string tag);
    int e;
    dd_mode = dd; pc_en = en;
    do_reset();
    for (int j = 0; j < n + 4; j++) begin
      flag_in = (j < n) ? s[j] : 1'b0;
      do @(negedge clk); while (!cell_take);
      @(negedge clk);
    end
    repeat (SLOT + 2) @(negedge clk);
    for (int j = 0; j < n; j++) begin
      checks++;
      if (s[j]) begin
        e = NOM + 1 + exp_shift(s, n, j, dd, en) * STEP;
        if (pcount[j] != 1 || pph[j] != e) begin
          errors++;
          $display("FAIL %s R3/R4 cell %0d: actual count %0d pos %0d expected count 1 pos %0d",
                   tag, j, pcount[j], pph[j], e);
        end
      end else if (pcount[j] != 0) begin
        errors++;
        $display("FAIL %s R3 cell %0d: actual count %0d expected 0", tag, j, pcount[j]);
      end
    end
    checks++;
    if (stray != 0 || wide != 0) begin
      errors++;
      $display("FAIL %s R11 actual stray %0d wide %0d expected 0 0", tag, stray, wide);
    end
  endtask

  task automatic t_reset_r1_r2();
    int k;
    rst_n = 0;
    repeat (2) @(negedge clk);
    checks++;
    if (wr_pulse !== 1'b0 || cell_take !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %b%b expected 00", wr_pulse, cell_take);
    end
    rst_n = 1;
    k = 0;
    do begin @(negedge clk); k++; end while (!cell_take && k < 100);
    checks++;
    if (k != SLOT - 1) begin
      errors++;
      $display("FAIL R1 first take: actual %0d expected %0d", k, SLOT - 1);
    end
    for (int r = 0; r < 3; r++) begin
      k = 0;
      do begin @(negedge clk); k++; end while (!cell_take && k < 100);
      checks++;
      if (k != SLOT) begin
        errors++;
        $display("FAIL R2 take spacing: actual %0d expected %0d", k, SLOT);
      end
    end
  endtask

  task automatic t_nominal_r4();  play(64'b1000000010001,            13, 1, 1, "R4 isolated"); endtask
  task automatic t_late_r5();     play(64'b10100000100100,           14, 1, 1, "R5 late");     endtask
  task automatic t_early_r6();    play(64'b1010010000000010100000,   22, 1, 1, "R6 early");    endtask
  task automatic t_outer_r7();    play(64'b100101000000010100001,    21, 1, 1, "R7 outer");    endtask
  task automatic t_none_r8();     play(64'b1010000000110100000110100, 25, 1, 1, "R8 none");   endtask
  task automatic t_illegal_r9();  play(64'b10110000000110100,        17, 1, 1, "R9 adjacent"); endtask
  task automatic t_fm_r10();      play(64'b10100100101001,           14, 0, 1, "R10 fm");      endtask
  task automatic t_off_r10();     play(64'b10100100101001,           14, 1, 0, "R10 off");     endtask
  task automatic t_mix_r3();
    play(64'h0000_00A5_2492_9449, 40, 1, 1, "R3 mixed stream");
  endtask

  initial begin
    t_reset_r1_r2();
    t_nominal_r4();
    t_late_r5();
    t_early_r6();
    t_outer_r7();
    t_none_r8();
    t_illegal_r9();
    t_fm_r10();
    t_off_r10();
    t_mix_r3();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule